// File: doc/BRIEF.md
# Wiper Stepping Sequencer for a 32-Tap Digital Potentiometer

This block sits on the host side of a three-wire digital potentiometer. It takes one command at a time on a valid/ready port. A command gives a direction, a step count from 0 to 31 and a flag that asks for the final position to be kept in the device's nonvolatile memory. The block then drives the select, direction and increment lines. Every minimum setup, hold, pulse-width and deselect interval is a parameter counted in clock cycles.

While it drives the lines, the block keeps a shadow of the wiper position it expects the device to hold. The shadow moves by one tap on each increment falling edge that it generates. It stops at tap 0 and at the top tap, as the device does. At the end of a command, the increment level at the moment select is released decides what happens. A high level makes the device write its counter to memory, and the block then waits the long store recovery time. A low level leaves memory untouched, and the block waits the short deselect time. When the recovery ends, a single-cycle done pulse is raised and the command port is ready again.

The command port follows valid/ready rules. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the sequencer is busy, `cmd_ready` is low, and a waiting source must hold its command stable until it is taken.

Top module: `dpot_step_ctrl`

## Requirements
- R1: After reset, `pot_cs_n` is 1, `pot_inc` is 1, `cmd_ready` is 1, `done` is 0 and `wiper_pos` equals the parameter `INIT_POS`.
- R2: A command is taken only while `cmd_ready` is high. A command offered while a sequence runs is ignored: it produces no extra increment edge, it does not change the final position, and it does not start a new sequence after `done`.
- R3: A command with N steps produces exactly N falling edges on `pot_inc` while `pot_cs_n` is 0. During those edges `pot_ud` is 1 when `cmd_up` was 1 and 0 otherwise.
- R4: `wiper_pos` moves by one on each generated falling edge, up when `pot_ud` is 1 and down when it is 0. It stays at 0 when moving down and at `TAPS-1` when moving up.
- R5: When the store flag is set, `pot_inc` is 1 on the edge where `pot_cs_n` rises. `pot_cs_n` then stays 1 for at least `T_REC_STORE` cycles before `done`.
- R6: When the store flag is clear and the step count is nonzero, `pot_inc` is 0 on the edge where `pot_cs_n` rises.
- R7: The following minimum intervals hold:
  - `pot_cs_n` is low for at least `T_CS_SETUP` cycles before the first falling edge of `pot_inc`.
  - `pot_ud` is stable for at least `T_DIR_SETUP` cycles before every falling edge, and `pot_ud` changes only while `pot_inc` is 1.
  - Increment low and high periods last at least `T_INC_LOW` and `T_INC_HIGH` cycles.
  - `pot_inc` is stable for at least `T_INC_TO_CS` cycles before `pot_cs_n` rises.
- R8: `done` is high for exactly one cycle at the end of each command. `cmd_ready` is high in that same cycle.
- R9: A zero-step command with the store flag set asserts `pot_cs_n` low and then releases it with `pot_inc` held at 1. It produces no falling edge and leaves `wiper_pos` unchanged.
- R10: A zero-step command with the store flag clear leaves `pot_cs_n` at 1 throughout. It raises `done` within `T_REC_NOSTORE`+1 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Sequencer is idle and takes the offered command |
| cmd_up | input | 1 | Direction: 1 moves toward the top tap, 0 toward tap 0 |
| cmd_steps | input | $clog2(TAPS) | Number of increment pulses, 0 to TAPS-1 |
| cmd_store | input | 1 | 1 writes the final position to device memory on release |
| pot_cs_n | output | 1 | Active-low device select |
| pot_ud | output | 1 | Direction line to the device |
| pot_inc | output | 1 | Increment line; each falling edge with select low moves one tap |
| wiper_pos | output | $clog2(TAPS) | Shadow of the expected wiper tap |
| done | output | 1 | One-cycle pulse when the command and its recovery finish |

## Verification
A wrong state register or a wrong remaining-step counter shows up at the ports within one command. It shows as a wrong number of increment falling edges, or as the wrong increment level at the cycle `pot_cs_n` rises. The store flag decides the release level, so a flipped or lost store bit changes the sampled release level and also the select-high interval before `done`. A shadow register that drifts from the generated edges shows up in `wiper_pos` as soon as `done` is seen, and at the ends of the range as a count that wraps past 0 or the top tap. A miscounting interval timer shortens one of the measured low, high, setup or deselect runs below its parameter within the same command.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETDIR,
    ST_INC_LOW,
    ST_INC_HIGH,
    ST_PRE_REL,
    ST_RELEASE,
    ST_RECOVER
  } seq_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dpot_interval.sv
// Down-counting interval timer shared by all sequencer states.
module dpot_interval #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7: a freshly loaded nonzero interval is never reported as over at once
  assert_load_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/dpot_shadow_pos.sv
// Shadow of the device wiper counter, saturating at both ends.
module dpot_shadow_pos #(
  parameter int unsigned TAPS     = 32,
  parameter int unsigned INIT_POS = 0,
  localparam int unsigned POS_W   = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = POS_W'(TAPS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= POS_W'(INIT_POS);
    else if (step) begin
      if (up && pos_q != TOP)         pos_q <= pos_q + 1'b1;
      else if (!up && pos_q != '0)    pos_q <= pos_q - 1'b1;
    end
  end

  assign pos = pos_q;

  assert_top_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && pos == TOP) |=> pos == TOP);
  assert_bottom_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up && pos == '0) |=> pos == '0);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));
endmodule

// File: rtl/dpot_step_ctrl.sv
module dpot_step_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned TAPS          = 32,
  parameter int unsigned INIT_POS      = 0,
  parameter int unsigned T_CS_SETUP    = 5,
  parameter int unsigned T_DIR_SETUP   = 145,
  parameter int unsigned T_INC_LOW     = 50,
  parameter int unsigned T_INC_HIGH    = 50,
  parameter int unsigned T_INC_TO_CS   = 50,
  parameter int unsigned T_REC_NOSTORE = 5,
  parameter int unsigned T_REC_STORE   = 500000,
  localparam int unsigned POS_W        = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_up,
  input  logic [POS_W-1:0] cmd_steps,
  input  logic             cmd_store,
  output logic             pot_cs_n,
  output logic             pot_ud,
  output logic             pot_inc,
  output logic [POS_W-1:0] wiper_pos,
  output logic             done
);
  localparam int unsigned T_MAX = max2(max2(max2(T_CS_SETUP, T_DIR_SETUP), max2(T_INC_LOW, T_INC_HIGH)),
                                       max2(T_INC_TO_CS, max2(T_REC_NOSTORE, T_REC_STORE)));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  localparam logic [CNT_W-1:0] L_CS   = CNT_W'(T_CS_SETUP - 1);
  localparam logic [CNT_W-1:0] L_DIR  = CNT_W'(T_DIR_SETUP - 1);
  localparam logic [CNT_W-1:0] L_LOW  = CNT_W'(T_INC_LOW - 1);
  localparam logic [CNT_W-1:0] L_HIGH = CNT_W'(T_INC_HIGH - 1);
  localparam logic [CNT_W-1:0] L_REL  = CNT_W'(T_INC_TO_CS - 1);
  localparam logic [CNT_W-1:0] L_RNS  = CNT_W'(T_REC_NOSTORE - 1);
  localparam logic [CNT_W-1:0] L_RST  = CNT_W'(T_REC_STORE - 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_exp, step;
  logic [CNT_W-1:0] tmr_val;
  logic [POS_W-1:0] left_q;
  logic             dir_q, store_q, ud_q, done_q;
  logic             accept;

  assign accept = cmd_valid && cmd_ready;

  dpot_interval #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  dpot_shadow_pos #(.TAPS(TAPS), .INIT_POS(INIT_POS)) i_shadow (
    .clk(clk), .rst_n(rst_n), .step(step), .up(ud_q), .pos(wiper_pos)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (cmd_steps == '0 && !cmd_store) begin
          state_d = ST_RECOVER;
          tmr_val = L_RNS;
        end else begin
          state_d = ST_SELECT;
          tmr_val = L_CS;
        end
      end
      ST_SELECT: if (tmr_exp) begin
        state_d = ST_SETDIR; tmr_load = 1'b1; tmr_val = L_DIR;
      end
      ST_SETDIR: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (left_q == '0) begin
          state_d = ST_PRE_REL; tmr_val = L_REL;
        end else begin
          state_d = ST_INC_LOW; tmr_val = L_LOW; step = 1'b1;
        end
      end
      ST_INC_LOW: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (left_q == '0 && !store_q) begin
          state_d = ST_PRE_REL; tmr_val = L_REL;
        end else begin
          state_d = ST_INC_HIGH; tmr_val = L_HIGH;
        end
      end
      ST_INC_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (left_q != '0) begin
          state_d = ST_INC_LOW; tmr_val = L_LOW; step = 1'b1;
        end else begin
          state_d = ST_PRE_REL; tmr_val = L_REL;
        end
      end
      ST_PRE_REL: if (tmr_exp) state_d = ST_RELEASE;
      ST_RELEASE: begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = store_q ? L_RST : L_RNS;
      end
      ST_RECOVER: if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      dir_q   <= 1'b0;
      store_q <= 1'b0;
      ud_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RECOVER) && tmr_exp;
      if (accept) begin
        left_q  <= cmd_steps;
        dir_q   <= cmd_up;
        store_q <= cmd_store;
      end else if (step) begin
        left_q <= left_q - 1'b1;
      end
      if (state_q == ST_SELECT && tmr_exp) ud_q <= dir_q;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign pot_cs_n  = (state_q == ST_IDLE) || (state_q == ST_RELEASE) || (state_q == ST_RECOVER);
  assign pot_inc   = !((state_q == ST_INC_LOW) ||
                       (((state_q == ST_PRE_REL) || (state_q == ST_RELEASE)) && !store_q));
  assign pot_ud    = ud_q;
  assign done      = done_q;

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pot_cs_n && pot_inc));
  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pot_cs_n |-> !cmd_ready);
  assert_fall_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pot_inc) |-> !pot_cs_n);
  assert_fall_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pot_inc) |-> (wiper_pos != $past(wiper_pos) || wiper_pos == '0 ||
                        wiper_pos == POS_W'(TAPS - 1)));
  assert_release_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pot_cs_n) |-> $stable(pot_inc));
  assert_ud_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pot_ud) |-> pot_inc);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

// File: tb/test_dpot_step_ctrl.sv
module test_dpot_step_ctrl;
  localparam int unsigned TAPS = 32;
  localparam int unsigned PW = $clog2(TAPS);
  localparam int unsigned CS_S = 2, DIR_S = 3, ILOW = 2, IHIGH = 3, I2CS = 2, RNS = 2, RST = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, cmd_store = 1'b0;
  logic [PW-1:0] cmd_steps = '0;
  logic cmd_ready, pot_cs_n, pot_ud, pot_inc, done;
  logic [PW-1:0] wiper_pos;

  always #10 clk = ~clk;   // 50 MHz

  dpot_step_ctrl #(
    .TAPS(TAPS), .INIT_POS(0), .T_CS_SETUP(CS_S), .T_DIR_SETUP(DIR_S), .T_INC_LOW(ILOW),
    .T_INC_HIGH(IHIGH), .T_INC_TO_CS(I2CS), .T_REC_NOSTORE(RNS), .T_REC_STORE(RST)
  ) i_dpot_step_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_up(cmd_up),
    .cmd_steps(cmd_steps), .cmd_store(cmd_store), .pot_cs_n(pot_cs_n), .pot_ud(pot_ud),
    .pot_inc(pot_inc), .wiper_pos(wiper_pos), .done(done)
  );

  int vectors = 0, errors = 0;
  int exp_pos = 0;

  // port monitor, sampled on falling clock edges
  int falls, cs_run, ud_run, inc_run, first_setup, min_ud, min_low, min_high;
  int rel_run, hi_run, hi_at_done, ud_bad;
  bit saw_sel, seen_rise, rel_inc, prev_inc = 1'b1, prev_cs = 1'b1, prev_ud = 1'b0;

  task automatic clear_mon();
    falls = 0; first_setup = -1; min_ud = 1000; min_low = 1000; min_high = 1000;
    rel_run = -1; hi_at_done = -1; saw_sel = 0; seen_rise = 0; rel_inc = 0; ud_bad = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int old_inc_run;
      old_inc_run = inc_run;
      if (pot_inc != prev_inc) begin
        if (!pot_inc && !pot_cs_n) begin
          falls++;
          if (falls == 1) first_setup = cs_run;
          if (ud_run < min_ud) min_ud = ud_run;
          if (seen_rise && inc_run < min_high) min_high = inc_run;
          if (pot_ud != cmd_up) ud_bad++;
        end
        if (pot_inc && !pot_cs_n) begin
          seen_rise = 1;
          if (inc_run < min_low) min_low = inc_run;
        end
        inc_run = 1;
      end else inc_run++;
      if (pot_ud != prev_ud) ud_run = 1; else ud_run++;
      if (done) hi_at_done = hi_run;
      if (pot_cs_n != prev_cs) begin
        if (!pot_cs_n) saw_sel = 1;
        else begin rel_inc = pot_inc; rel_run = old_inc_run; hi_run = 0; end
        cs_run = 1;
      end else cs_run++;
      if (pot_cs_n) hi_run++;
      prev_inc = pot_inc; prev_cs = pot_cs_n; prev_ud = pot_ud;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int p, input bit up, input int n);
    int r = p;
    for (int i = 0; i < n; i++) begin
      if (up && r < TAPS - 1) r++;
      else if (!up && r > 0) r--;
    end
    return r;
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done, "R8 done seen", done, 1);
    @(negedge clk);
    check(!done && cmd_ready, "R8 single pulse", done, 0);
  endtask

  task automatic issue(input bit up, input int n, input bit st);
    @(negedge clk);
    clear_mon();
    check(cmd_ready, "R2 ready before issue", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_up = up; cmd_steps = PW'(n); cmd_store = st;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_timing(input int n);
    if (n > 0) begin
      check(first_setup >= CS_S, "R7 cs setup", first_setup, CS_S);
      check(min_ud >= DIR_S, "R7 dir setup", min_ud, DIR_S);
      check(min_low >= ILOW || n == 1, "R7 inc low", min_low, ILOW);
      check(min_high >= IHIGH || n == 1, "R7 inc high", min_high, IHIGH);
      check(ud_bad == 0, "R3 ud level", ud_bad, 0);
    end
    check(rel_run >= I2CS, "R7 inc before release", rel_run, I2CS);
  endtask

  task automatic t_move(input bit up, input int n, input bit st);
    int c;
    issue(up, n, st);
    wait_done(c);
    exp_pos = model(exp_pos, up, n);
    check(falls == n, "R3 falling edges", falls, n);
    check(int'(wiper_pos) == exp_pos, "R4 shadow position", wiper_pos, exp_pos);
    check(rel_inc == st, st ? "R5 store release level" : "R6 no-store release level", rel_inc, st);
    if (st) check(hi_at_done >= RST, "R5 store recovery", hi_at_done, RST);
    else check(hi_at_done >= RNS, "R6 deselect time", hi_at_done, RNS);
    check_timing(n);
  endtask

  task automatic t_reset();
    check(pot_cs_n && pot_inc && cmd_ready && !done, "R1 idle lines",
          {pot_cs_n, pot_inc, cmd_ready, done}, 4'b1110);
    check(wiper_pos == 0, "R1 init position", wiper_pos, 0);
  endtask

  task automatic t_zero_store();
    int c;
    issue(1'b1, 0, 1'b1);
    wait_done(c);
    check(saw_sel, "R9 select asserted", saw_sel, 1);
    check(falls == 0, "R9 no edges", falls, 0);
    check(rel_inc, "R9 release level", rel_inc, 1);
    check(int'(wiper_pos) == exp_pos, "R9 position kept", wiper_pos, exp_pos);
  endtask

  task automatic t_zero_nostore();
    int c;
    issue(1'b0, 0, 1'b0);
    wait_done(c);
    check(!saw_sel, "R10 select idle", saw_sel, 0);
    check(c <= RNS + 1, "R10 done latency", c, RNS + 1);
    check(int'(wiper_pos) == exp_pos, "R10 position kept", wiper_pos, exp_pos);
  endtask

  task automatic t_busy_ignore();
    int c;
    issue(1'b1, 4, 1'b0);
    cmd_valid = 1'b1; cmd_up = 1'b0; cmd_steps = PW'(9); cmd_store = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!cmd_ready, "R2 ready low while busy", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    wait_done(c);
    exp_pos = model(exp_pos, 1'b1, 4);
    check(falls == 4, "R2 no extra edges", falls, 4);
    check(int'(wiper_pos) == exp_pos, "R2 position unaffected", wiper_pos, exp_pos);
    check(pot_cs_n, "R2 no new sequence", pot_cs_n, 1);
  endtask

  initial begin
    clear_mon();
    inc_run = 0; cs_run = 0; ud_run = 0; hi_run = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_move(1'b1, 5, 1'b0);     // up, no store
    t_move(1'b0, 3, 1'b1);     // down, store
    t_move(1'b1, 31, 1'b1);    // saturate at top (R4)
    t_move(1'b1, 1, 1'b0);     // already at top, single step
    t_move(1'b0, 31, 1'b0);    // to bottom
    t_move(1'b0, 4, 1'b1);     // saturate at bottom (R4)
    t_zero_store();
    t_zero_nostore();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule